// File: doc/BRIEF.md
# Halfword-Select Signed Multiply Unit

This unit sits in an execution pipeline after the register file read. It takes one 32-bit instruction word and a mode bit that says which encoding the word uses: the fixed-width 32-bit layout, or the compact layout made of two halfwords. It decides whether the word is one of four signed halfword multiply forms. For each of the two source operands, an instruction bit picks either the upper or the lower 16 bits. The two picked halves are multiplied as signed numbers, and the full 32-bit product is returned together with the destination register index.

Decode results appear combinationally in the same cycle: the match flag, the three register indices and an unpredictable flag. The product, its destination index and a valid pulse are registered and appear one cycle after the input strobe. A 16x16 signed product always fits in 32 bits, so the unit reports no overflow or saturation. Latency is fixed and does not depend on the operand values.

Top module: `hsm_unit`

## Requirements
- R1: With enc_mode=0, a word matches when bits 27:20 are 00010110, bit 7 is 1, bit 4 is 0 and bits 31:28 are not 1111. In that layout rd_idx comes from bits 19:16, rm_idx from bits 11:8 and rn_idx from bits 3:0. Bit 6 selects the half of the second operand (op_b) and bit 5 selects the half of the first operand (op_a).
- R2: With enc_mode=1, the word is the first halfword in bits 31:16 and the second halfword in bits 15:0. It matches when first[15:4]=111110110001, second[15:12]=1111 and second[7:6]=00. In that layout rn_idx is first[3:0], rd_idx is second[11:8], rm_idx is second[3:0], second bit 5 selects the op_a half and second bit 4 selects the op_b half.
- R3: A select bit of 0 takes bits 15:0 of its operand and a select bit of 1 takes bits 31:16. The unselected half has no effect on the result.
- R4: The result is the low 32 bits of the signed two's-complement product of the two selected halves. 0x8000 times 0x8000 gives 0x40000000, and 0x8000 times 0x7FFF gives 0xC0008000.
- R5: When in_valid is high and the word matches, res_valid is high on the next cycle, with result and res_rd (the destination index) for that word. res_valid stays high for only one cycle per strobe.
- R6: A word that does not match drives is_match low, reads unpred and all indices as zero, and produces no res_valid.
- R7: For a matching word, unpred is high when any of rd_idx, rn_idx or rm_idx equals 15.
- R8: With enc_mode=0, nonzero bits 15:12 still match but raise unpred.
- R9: Latency from in_valid to res_valid is exactly one cycle for every operand value.
- R10: During reset res_valid, result and res_rd are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| enc_mode | input | 1 | 0 = 32-bit layout, 1 = two-halfword layout |
| instr | input | 32 | Instruction word |
| op_a | input | DATA_W | Value of the first source register (half chosen by the op_a select bit) |
| op_b | input | DATA_W | Value of the second source register (half chosen by the op_b select bit) |
| is_match | output | 1 | Word is one of the four multiply forms |
| rd_idx | output | 4 | Destination register index |
| rn_idx | output | 4 | First source register index |
| rm_idx | output | 4 | Second source register index |
| unpred | output | 1 | Unpredictable register use or nonzero reserved field |
| res_valid | output | 1 | One-cycle pulse: result is valid |
| result | output | DATA_W | Signed 32-bit product |
| res_rd | output | 4 | Destination index that goes with result |

## Verification
The assertions assume that instr, enc_mode and both operands are known, stable values whenever in_valid is high. They also assume that enc_mode truly names the layout of the word, since a wide word presented in compact mode is simply treated as a non-match. The stimulus drives all inputs at the falling clock edge and holds them for a full cycle. Its words are built from field-level helper functions, so each test either lands on a legal layout on purpose or is broken on purpose by corrupting a fixed-pattern bit. Random operands and register fields cover sign boundaries, every half-select combination and index 15.

// File: rtl/hsm_pkg.sv
// Package: shared decode record for the halfword signed multiply unit.
// Assumes register indices are always 4 bits wide in both encodings.
package hsm_pkg;
    localparam int IDX_W = 4;
    localparam int INSTR_W = 32;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
        logic             rn_hi;
        logic             rm_hi;
        logic             rsv_bad;
    } hsm_dec_t;
endpackage

// File: rtl/hsm_dec_wide.sv
// Decoder for the fixed-width 32-bit encoding.
// Assumes the full word is valid on the input; purely combinational.
module hsm_dec_wide
    import hsm_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output hsm_dec_t           dec
);
    localparam logic [3:0] COND_NEVER = 4'b1111;
    localparam logic [7:0] OPC_FIXED  = 8'b0001_0110;

    logic cond_ok;
    logic opc_ok;
    logic mark_ok;

    // Check the fixed opcode bits and the condition field.
    always_comb begin
        cond_ok = (word[31:28] != COND_NEVER);
        opc_ok  = (word[27:20] == OPC_FIXED);
        mark_ok = word[7] && !word[4];
    end

    // Pull out the register fields and the half selects.
    always_comb begin
        dec.hit     = cond_ok && opc_ok && mark_ok;
        dec.rd      = word[19:16];
        dec.rm      = word[11:8];
        dec.rn      = word[3:0];
        dec.rm_hi   = word[6];
        dec.rn_hi   = word[5];
        dec.rsv_bad = (word[15:12] != 4'd0);
    end
endmodule

// File: rtl/hsm_dec_compact.sv
// Decoder for the two-halfword compact encoding.
// Assumes the first halfword sits in bits 31:16 and the second in 15:0.
module hsm_dec_compact
    import hsm_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output hsm_dec_t           dec
);
    localparam logic [11:0] HW1_FIXED = 12'hFB1;
    localparam logic [3:0]  HW2_FIXED = 4'hF;

    logic [15:0] hw_first;
    logic [15:0] hw_second;

    // Split the word into its two halfwords.
    always_comb begin
        hw_first  = word[31:16];
        hw_second = word[15:0];
    end

    // Match the fixed bits and extract the fields.
    always_comb begin
        dec.hit     = (hw_first[15:4] == HW1_FIXED) &&
                      (hw_second[15:12] == HW2_FIXED) &&
                      (hw_second[7:6] == 2'b00);
        dec.rn      = hw_first[3:0];
        dec.rd      = hw_second[11:8];
        dec.rm      = hw_second[3:0];
        dec.rn_hi   = hw_second[5];
        dec.rm_hi   = hw_second[4];
        dec.rsv_bad = 1'b0;
    end
endmodule

// File: rtl/hsm_half_sel.sv
// Picks the upper or lower half of an operand.
// Assumes DATA_W is even; the unselected half never reaches the output.
module hsm_half_sel #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] val,
    input  logic              take_hi,
    output logic [HALF_W-1:0] half
);
    // Two-way select between the halves.
    always_comb begin
        half = take_hi ? val[DATA_W-1:HALF_W] : val[HALF_W-1:0];
    end
endmodule

// File: rtl/hsm_mul.sv
// Signed HALF_W x HALF_W multiplier with a full-width product.
// Assumes both inputs are two's complement; the product always fits.
module hsm_mul #(
    parameter int HALF_W = 16,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    output logic [PROD_W-1:0] p
);
    logic signed [HALF_W-1:0] sa;
    logic signed [HALF_W-1:0] sb;
    logic signed [PROD_W-1:0] sp;

    // Sign-interpret the inputs and form the product.
    always_comb begin
        sa = $signed(a);
        sb = $signed(b);
        sp = PROD_W'(sa) * PROD_W'(sb);
        p  = sp;
    end
endmodule

// File: rtl/hsm_unit.sv
// Top: decodes either encoding, selects halves, multiplies, and registers
// the product. Assumes operands are already read for the indexed registers.
module hsm_unit
    import hsm_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int NUM_OPS = 2,
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               enc_mode,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    output logic               is_match,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [IDX_W-1:0]   rn_idx,
    output logic [IDX_W-1:0]   rm_idx,
    output logic               unpred,
    output logic               res_valid,
    output logic [DATA_W-1:0]  result,
    output logic [IDX_W-1:0]   res_rd
);
    hsm_dec_t dec_w;
    hsm_dec_t dec_c;
    hsm_dec_t dec_s;

    logic [DATA_W-1:0] ops    [NUM_OPS];
    logic              sel_hi [NUM_OPS];
    logic [HALF_W-1:0] halves [NUM_OPS];
    logic [DATA_W-1:0] prod;
    logic              fire;

    hsm_dec_wide    u_dec_w (.word(instr), .dec(dec_w));
    hsm_dec_compact u_dec_c (.word(instr), .dec(dec_c));

    // Choose the decode record for the current encoding.
    always_comb begin
        dec_s = enc_mode ? dec_c : dec_w;
    end

    // Drive the decode outputs; zeros when nothing matched.
    always_comb begin
        is_match = dec_s.hit;
        rd_idx   = dec_s.hit ? dec_s.rd : '0;
        rn_idx   = dec_s.hit ? dec_s.rn : '0;
        rm_idx   = dec_s.hit ? dec_s.rm : '0;
        unpred   = dec_s.hit && ((dec_s.rd == IDX_MAX) || (dec_s.rn == IDX_MAX) ||
                                 (dec_s.rm == IDX_MAX) || dec_s.rsv_bad);
    end

    // Gather the operand values and their half selects.
    always_comb begin
        ops[0]    = op_a;
        ops[1]    = op_b;
        sel_hi[0] = dec_s.rn_hi;
        sel_hi[1] = dec_s.rm_hi;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_sel
        hsm_half_sel #(.DATA_W(DATA_W)) u_sel (
            .val(ops[g]), .take_hi(sel_hi[g]), .half(halves[g])
        );
    end

    hsm_mul #(.HALF_W(HALF_W)) u_mul (.a(halves[0]), .b(halves[1]), .p(prod));

    // Strobe qualified by a legal match.
    always_comb begin
        fire = in_valid && dec_s.hit;
    end

    // Result register with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            res_rd    <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                result <= prod;
                res_rd <= dec_s.rd;
            end
        end
    end
endmodule

// File: rtl/hsm_unit_chk.sv
// Checker for hsm_unit: protocol, product and flag properties on the ports.
// Assumes inputs are known whenever in_valid is high.
module hsm_unit_chk #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              enc_mode,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              is_match,
    input logic [3:0]        rd_idx,
    input logic [3:0]        rn_idx,
    input logic [3:0]        rm_idx,
    input logic              unpred,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        res_rd
);
    logic signed [HALF_W-1:0] ca;
    logic signed [HALF_W-1:0] cb;
    logic        [DATA_W-1:0] cprod;

    // Reference product computed from the port-level field positions.
    always_comb begin
        ca    = instr[5] ? op_a[DATA_W-1:HALF_W] : op_a[HALF_W-1:0];
        cb    = (enc_mode ? instr[4] : instr[6]) ? op_b[DATA_W-1:HALF_W] : op_b[HALF_W-1:0];
        cprod = DATA_W'(DATA_W'(ca) * DATA_W'(cb));
    end

    a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_match) |=> res_valid);

    a_r6_no_valid_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_match) |=> !res_valid);

    // R3 and R4: the registered result equals the signed product of the chosen halves.
    a_r4_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_match) |=> (result == $past(cprod)));

    a_r5_dest_carried: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_match) |=> (res_rd == $past(rd_idx)));

    a_r7_unpred_idx15: assert property (@(posedge clk) disable iff (!rst_n)
        (is_match && (rd_idx == 4'hF || rn_idx == 4'hF || rm_idx == 4'hF)) |-> unpred);

    a_r8_rsv_field: assert property (@(posedge clk) disable iff (!rst_n)
        (is_match && !enc_mode && instr[15:12] != 4'd0) |-> unpred);

    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_match |-> (!unpred && rd_idx == 4'd0 && rn_idx == 4'd0 && rm_idx == 4'd0));
endmodule

bind hsm_unit hsm_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_mode(enc_mode),
    .instr(instr), .op_a(op_a), .op_b(op_b), .is_match(is_match),
    .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx), .unpred(unpred),
    .res_valid(res_valid), .result(result), .res_rd(res_rd)
);

// File: tb/hsm_unit_tb.sv
module hsm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        enc_mode = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        is_match, unpred, res_valid;
    logic [3:0]  rd_idx, rn_idx, rm_idx, res_rd;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hsm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_mode(enc_mode),
        .instr(instr), .op_a(op_a), .op_b(op_b), .is_match(is_match),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx), .unpred(unpred),
        .res_valid(res_valid), .result(result), .res_rd(res_rd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_wide(input logic [3:0] cond, input logic [3:0] rd,
        input logic [3:0] rsv, input logic [3:0] rm, input bit mh, input bit nh, input logic [3:0] rn);
        return {cond, 8'b0001_0110, rd, rsv, rm, 1'b1, mh, nh, 1'b0, rn};
    endfunction

    function automatic logic [31:0] mk_cmp(input logic [3:0] rn, input logic [3:0] rd,
        input bit nh, input bit mh, input logic [3:0] rm);
        return {12'hFB1, rn, 4'hF, rd, 2'b00, nh, mh, rm};
    endfunction

    function automatic logic [31:0] ref_prod(input logic [31:0] a, input logic [31:0] b, input bit nh, input bit mh);
        logic signed [15:0] x;
        logic signed [15:0] y;
        x = nh ? a[31:16] : a[15:0];
        y = mh ? b[31:16] : b[15:0];
        return 32'(int'(x) * int'(y));
    endfunction

    task automatic run(input bit mode, input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
        input bit hit, input bit unp, input logic [3:0] rd, input logic [31:0] exp_res, input string req);
        @(negedge clk);
        enc_mode = mode; instr = w; op_a = a; op_b = b; in_valid = 1'b1;
        #1;
        chk(is_match == hit, {req, " match"}, 32'(is_match), 32'(hit));
        chk(unpred == (hit && unp), {req, " R7 unpred"}, 32'(unpred), 32'(hit && unp));
        chk(rd_idx == (hit ? rd : 4'd0), {req, " rd_idx"}, 32'(rd_idx), 32'(hit ? rd : 4'd0));
        @(negedge clk);
        in_valid = 1'b0;
        chk(res_valid == hit, {req, " R9 res_valid"}, 32'(res_valid), 32'(hit));
        if (hit) begin
            chk(result == exp_res, {req, " R4 result"}, result, exp_res);
            chk(res_rd == rd, {req, " R5 res_rd"}, 32'(res_rd), 32'(rd));
        end
        @(negedge clk);
        chk(res_valid == 1'b0, {req, " R5 single pulse"}, 32'(res_valid), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(res_valid == 1'b0 && result == 32'd0 && res_rd == 4'd0, "R10 reset", result, 32'd0);
        rst_n = 1'b1;

        // R4 corner products
        run(0, mk_wide(4'hE, 4'd2, 4'd0, 4'd3, 0, 0, 4'd1), 32'h1234_8000, 32'h5678_8000,
            1, 0, 4'd2, 32'h4000_0000, "R1 R4 min*min");
        run(1, mk_cmp(4'd4, 4'd5, 1, 1, 4'd6), 32'h8000_0001, 32'h7FFF_FFFF,
            1, 0, 4'd5, 32'hC000_8000, "R2 R4 min*max");
        // R3: all four selections, both encodings, other half holds noise
        for (int s = 0; s < 4; s++) begin
            bit nh = s[1];
            bit mh = s[0];
            run(0, mk_wide(4'h0, 4'd7, 4'd0, 4'd8, mh, nh, 4'd9), 32'hFFFE_0003, 32'h0005_FFF9,
                1, 0, 4'd7, ref_prod(32'hFFFE_0003, 32'h0005_FFF9, nh, mh), "R3 wide select");
            run(1, mk_cmp(4'd9, 4'd7, nh, mh, 4'd8), 32'hFFFE_0003, 32'h0005_FFF9,
                1, 0, 4'd7, ref_prod(32'hFFFE_0003, 32'h0005_FFF9, nh, mh), "R3 compact select");
        end
        // R7: index 15
        run(0, mk_wide(4'h1, 4'hF, 4'd0, 4'd1, 0, 1, 4'd2), 32'h0002_0000, 32'h0000_0003,
            1, 1, 4'hF, 32'd6, "R7 rd15");
        run(1, mk_cmp(4'hF, 4'd1, 0, 0, 4'd2), 32'h0000_0004, 32'h0000_FFFF,
            1, 1, 4'd1, 32'hFFFF_FFFC, "R7 rn15");
        // R8: reserved field nonzero
        run(0, mk_wide(4'h2, 4'd1, 4'h8, 4'd1, 0, 0, 4'd1), 32'd10, 32'd11,
            1, 1, 4'd1, 32'd110, "R8 rsv nonzero");
        // R6: misses
        run(0, mk_wide(4'hF, 4'd1, 4'd0, 4'd1, 0, 0, 4'd1), 32'd1, 32'd1, 0, 0, 4'd0, 32'd0, "R6 R1 cond never");
        run(0, mk_wide(4'h0, 4'd1, 4'd0, 4'd1, 0, 0, 4'd1) ^ 32'h0000_0080, 32'd1, 32'd1, 0, 0, 4'd0, 32'd0, "R6 R1 bit7");
        run(1, mk_cmp(4'd1, 4'd1, 0, 0, 4'd1) | 32'h0000_0040, 32'd1, 32'd1, 0, 0, 4'd0, 32'd0, "R6 R2 bits7:6");
        run(1, mk_wide(4'h0, 4'd1, 4'd0, 4'd1, 0, 0, 4'd1), 32'd1, 32'd1, 0, 0, 4'd0, 32'd0, "R6 R2 wrong mode");

        // Random legal and broken words; R9 latency is checked for every operand pair
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            logic [3:0]  rd = 4'($urandom);
            logic [3:0]  rn = 4'($urandom);
            logic [3:0]  rm = 4'($urandom);
            bit          nh = 1'($urandom);
            bit          mh = 1'($urandom);
            bit          mode = 1'($urandom);
            bit          brk = ($urandom % 8) == 0;
            logic [3:0]  cond = 4'($urandom % 15);
            logic [3:0]  rsv = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
            logic [31:0] w;
            bit          unp;
            if (mode) begin
                w = mk_cmp(rn, rd, nh, mh, rm);
                if (brk) w = w ^ 32'h0010_0000;
                unp = (rd == 4'hF) || (rn == 4'hF) || (rm == 4'hF);
            end else begin
                w = mk_wide(cond, rd, rsv, rm, mh, nh, rn);
                if (brk) w = w ^ 32'h0100_0000;
                unp = (rd == 4'hF) || (rn == 4'hF) || (rm == 4'hF) || (rsv != 4'd0);
            end
            run(mode, w, a, b, !brk, unp, rd, ref_prod(a, b, nh, mh), "R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule